// File: doc/BRIEF.md
# Gated Card Clock Generator

This block derives the clock that drives a memory card bus from the module clock. Software writes one control word. The word holds a one-hot ratio field, an output enable, a bypass selector and an idle-gating switch. The block then produces a square wave at the module clock divided by a power of two between 2 and 1024. In bypass mode it passes the module clock through unchanged.

The output never carries a shortened high or low phase. When the clock is stopped, it first completes the phase in progress and then holds low after a full low phase. When it is started, it begins with a full high phase. The ratio and bypass selection are captured only when the clock starts. To change the rate, software clears the enable, writes the new ratio, and sets the enable again.

With idle gating on, the clock runs only while the transfer-busy input is high and for a fixed number of cycles after it falls. Between transfers the card sees a quiet line.

Top module: `card_clk_gen`

## Requirements
- R1: After reset the card clock is low and the control word reads back as zero.
- R2: A write strobe stores the ratio bits 7..0, enable bit 8, idle-gating bit 9, bypass bit 10 and (when the capability parameter is set) divide-by-1024 bit 16. All other bits read as zero, and the stored word does not change without a strobe.
- R3: With bypass and bit 16 clear, the output has equal high and low phases. Ratio bit k (0..7) gives a period of 2^(k+2) module cycles, no ratio bit gives 2 cycles, and bit 16 gives 1024 cycles.
- R4: When several of the bits 16, 10 and 7..0 are set, the highest-numbered set bit decides the mode.
- R5: In bypass mode the card clock is high while the module clock is high and low while it is low.
- R6: Clearing the enable lets the current high phase and the following low phase finish at full length. After that the output stays low.
- R7: A stopped clock starts with a high phase one module cycle after the enable is stored. A ratio written while the clock runs has no effect until the next start.
- R8: With bit 9 set, the clock stays stopped while the busy input is low. It runs while busy is high and for 8 further module cycles after busy falls, and then stops at the end of a low phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | REG_W | Control word write data |
| cfg_rdata | output | REG_W | Stored control word |
| xfer_busy | input | 1 | Command or data transfer in progress |
| card_clk | output | 1 | Generated card clock |

## Verification
The hardest case to reach is a disable that lands in the middle of a high phase. The bench waits until it has seen the rising edge of a 16-cycle period and then drops the enable two cycles later. It checks that the high phase still lasts eight samples and that no further high appears. The hold-off after busy falls is reached by running at the fastest ratio, so the 8 lingering cycles show several pulses before the output settles low. The ratio latch is exercised by rewriting the ratio while the clock runs and measuring both before and after a restart.

// File: rtl/card_clk_pkg.sv
package card_clk_pkg;
   localparam int RATIO_LO_W = 8;
   localparam int BIT_EN     = 8;
   localparam int BIT_IDLE   = 9;
   localparam int BIT_BYP    = 10;
   localparam int BIT_X1024  = 16;
   localparam int HALF_W     = RATIO_LO_W + 1;

   typedef struct packed {
      logic              bypass;
      logic [HALF_W-1:0] half_m1;
   } clk_mode_t;
endpackage

// File: rtl/card_clk_regs.sv
module card_clk_regs
   import card_clk_pkg::*;
#(
   parameter int REG_W     = 32,
   parameter bit HAS_X1024 = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr,
   input  logic [REG_W-1:0]      wdata,
   output logic [REG_W-1:0]      rdata,
   output logic [RATIO_LO_W-1:0] ratio_lo,
   output logic                  x1024,
   output logic                  bypass,
   output logic                  en,
   output logic                  idle_mode
);
   logic unused_wdata;
   assign unused_wdata = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ratio_lo  <= '0;
         en        <= 1'b0;
         idle_mode <= 1'b0;
         bypass    <= 1'b0;
      end else if (wr) begin
         ratio_lo  <= wdata[RATIO_LO_W-1:0];
         en        <= wdata[BIT_EN];
         idle_mode <= wdata[BIT_IDLE];
         bypass    <= wdata[BIT_BYP];
      end
   end

   generate
      if (HAS_X1024) begin : g_x1024
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  x1024 <= 1'b0;
            else if (wr) x1024 <= wdata[BIT_X1024];
         end
      end else begin : g_no_x1024
         assign x1024 = 1'b0;
      end
   endgenerate

   always_comb begin
      rdata                      = '0;
      rdata[RATIO_LO_W-1:0]      = ratio_lo;
      rdata[BIT_EN]              = en;
      rdata[BIT_IDLE]            = idle_mode;
      rdata[BIT_BYP]             = bypass;
      rdata[BIT_X1024]           = x1024;
   end

   // R2
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(rdata));
endmodule

// File: rtl/card_clk_decode.sv
module card_clk_decode
   import card_clk_pkg::*;
(
   input  logic [RATIO_LO_W-1:0] ratio_lo,
   input  logic                  x1024,
   input  logic                  bypass,
   output clk_mode_t             mode
);
   always_comb begin
      mode.bypass  = 1'b0;
      mode.half_m1 = '0;
      for (int k = 0; k < RATIO_LO_W; k++) begin
         if (ratio_lo[k]) mode.half_m1 = HALF_W'((32'd1 << (k + 1)) - 32'd1);
      end
      if (bypass) begin
         mode.bypass  = 1'b1;
         mode.half_m1 = '0;
      end
      if (x1024) begin
         mode.bypass  = 1'b0;
         mode.half_m1 = HALF_W'((32'd1 << (RATIO_LO_W + 1)) - 32'd1);
      end
   end
endmodule

// File: rtl/card_clk_idle.sv
module card_clk_idle #(
   parameter int LINGER_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic idle_mode,
   input  logic busy,
   output logic run
);
   localparam int LW = $clog2(LINGER_CYC + 1);

   logic [LW-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            left <= '0;
      else if (busy)         left <= LW'(LINGER_CYC);
      else if (left != '0)   left <= left - 1'b1;
   end

   assign run = en && (!idle_mode || busy || (left != '0));

   // R8
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) |-> (left == LW'(LINGER_CYC)));

   // R8
   drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && left != '0) |=> (left == $past(left) - 1'b1));
endmodule

// File: rtl/card_clk_phase.sv
module card_clk_phase
   import card_clk_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      run,
   input  clk_mode_t mode_in,
   output logic      card_clk
);
   logic              running;
   logic              ck_q;
   logic              gate_n;
   logic [HALF_W-1:0] cnt;
   clk_mode_t         mode_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running  <= 1'b0;
         ck_q     <= 1'b0;
         cnt      <= '0;
         mode_act <= '0;
      end else if (!running) begin
         ck_q <= 1'b0;
         cnt  <= '0;
         if (run) begin
            running  <= 1'b1;
            mode_act <= mode_in;
            ck_q     <= !mode_in.bypass;
         end
      end else if (mode_act.bypass) begin
         if (!run) running <= 1'b0;
      end else if (cnt == mode_act.half_m1) begin
         cnt <= '0;
         if (ck_q)     ck_q    <= 1'b0;
         else if (run) ck_q    <= 1'b1;
         else          running <= 1'b0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) gate_n <= 1'b0;
      else        gate_n <= running && mode_act.bypass;
   end

   assign card_clk = mode_act.bypass ? (clk & gate_n) : ck_q;

   // R6
   stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(running) |-> !ck_q);

   // R7
   restart_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(running) && !mode_act.bypass) |-> ck_q);

   // R7
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (running && $past(running)) |-> $stable(mode_act));

   // R3
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (cnt <= mode_act.half_m1));
endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen
   import card_clk_pkg::*;
#(
   parameter int REG_W      = 32,
   parameter bit HAS_X1024  = 1'b1,
   parameter int LINGER_CYC = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [REG_W-1:0] cfg_wdata,
   output logic [REG_W-1:0] cfg_rdata,
   input  logic             xfer_busy,
   output logic             card_clk
);
   generate
      if (REG_W <= BIT_X1024) begin : g_bad_width
         $error("card_clk_gen: REG_W too narrow for the control word");
      end
      if (LINGER_CYC < 1) begin : g_bad_linger
         $error("card_clk_gen: LINGER_CYC must be at least 1");
      end
   endgenerate

   logic [RATIO_LO_W-1:0] ratio_lo;
   logic                  x1024, bypass, en, idle_mode, run;
   clk_mode_t             mode;

   card_clk_regs #(.REG_W(REG_W), .HAS_X1024(HAS_X1024)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata),
      .rdata(cfg_rdata), .ratio_lo(ratio_lo), .x1024(x1024),
      .bypass(bypass), .en(en), .idle_mode(idle_mode)
   );

   card_clk_decode u_decode (
      .ratio_lo(ratio_lo), .x1024(x1024), .bypass(bypass), .mode(mode)
   );

   card_clk_idle #(.LINGER_CYC(LINGER_CYC)) u_idle (
      .clk(clk), .rst_n(rst_n), .en(en), .idle_mode(idle_mode),
      .busy(xfer_busy), .run(run)
   );

   card_clk_phase u_phase (
      .clk(clk), .rst_n(rst_n), .run(run), .mode_in(mode),
      .card_clk(card_clk)
   );
endmodule

// File: tb/card_clk_gen_test.sv
module card_clk_gen_test;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] EN   = 32'h0000_0100;
   localparam logic [31:0] IDLE = 32'h0000_0200;
   localparam logic [31:0] BYP  = 32'h0000_0400;
   localparam logic [31:0] X1K  = 32'h0001_0000;
   localparam int NVEC = 6;
   localparam logic [31:0] VEC_CTL [NVEC] = '{
      32'h0000_0000, 32'h0000_0001, 32'h0000_0004,
      32'h0000_0080, X1K | 32'h0000_0002, 32'h0000_0024 };
   localparam int VEC_HALF [NVEC] = '{1, 2, 8, 256, 512, 64};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        xfer_busy = 1'b0;
   logic        card_clk;
   int total = 0;
   int bad = 0;

   card_clk_gen uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .xfer_busy(xfer_busy), .card_clk(card_clk)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr_cfg(input logic [31:0] v);
      @(negedge clk);
      cfg_wr = 1'b1;
      cfg_wdata = v;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic idle_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic measure(output int hi, output int lo);
      int g;
      hi = 0; lo = 0; g = 0;
      @(negedge clk);
      while (card_clk !== 1'b0 && g < 3000) begin @(negedge clk); g++; end
      while (card_clk !== 1'b1 && g < 3000) begin @(negedge clk); g++; end
      while (card_clk === 1'b1 && hi < 3000) begin hi++; @(negedge clk); end
      while (card_clk === 1'b0 && lo < 3000) begin lo++; @(negedge clk); end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int hi, lo, ones_after, rises;
      bit seen_low, ok;
      logic prev;
      idle_cyc(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(card_clk === 1'b0, "R1 card low", int'(card_clk), 0);
      chk(cfg_rdata === 32'h0, "R1 rdata zero", int'(cfg_rdata), 0);

      // R2 stored fields and ignored bits
      wr_cfg(32'hFFFF_FFFF);
      chk(cfg_rdata === 32'h0001_07FF, "R2 readback", int'(cfg_rdata), 32'h107FF);
      cfg_wdata = 32'h1234_5678;
      idle_cyc(3);
      chk(cfg_rdata === 32'h0001_07FF, "R2 no strobe", int'(cfg_rdata), 32'h107FF);
      wr_cfg(32'h0);
      idle_cyc(1100);

      // R3 / R4 table of ratios
      for (int v = 0; v < NVEC; v++) begin
         wr_cfg(VEC_CTL[v]);
         wr_cfg(VEC_CTL[v] | EN);
         measure(hi, lo);
         chk(hi == VEC_HALF[v], (v >= 4) ? "R4 high phase" : "R3 high phase", hi, VEC_HALF[v]);
         chk(lo == VEC_HALF[v], (v >= 4) ? "R4 low phase" : "R3 low phase", lo, VEC_HALF[v]);
         wr_cfg(VEC_CTL[v]);
         idle_cyc(1100);
      end

      // R7 start latency: high phase one cycle after enable stored
      wr_cfg(32'h4 | EN);
      chk(card_clk === 1'b0, "R7 before start", int'(card_clk), 0);
      @(negedge clk);
      chk(card_clk === 1'b1, "R7 starts high", int'(card_clk), 1);

      // R6 disable in mid high phase
      seen_low = 1'b0;
      while (!seen_low) begin @(negedge clk); if (card_clk === 1'b0) seen_low = 1'b1; end
      while (card_clk !== 1'b1) @(negedge clk);
      hi = 1; ones_after = 0; seen_low = 1'b0;
      for (int i = 0; i < 80; i++) begin
         @(negedge clk);
         if (i == 0) begin cfg_wr = 1'b1; cfg_wdata = 32'h4; end
         if (i == 1) cfg_wr = 1'b0;
         if (card_clk === 1'b0) seen_low = 1'b1;
         else if (!seen_low) hi++;
         else ones_after++;
      end
      chk(hi == 8, "R6 high phase completes", hi, 8);
      chk(ones_after == 0, "R6 holds low", ones_after, 0);

      // R7 ratio written while running is ignored until restart
      wr_cfg(32'h4 | EN);
      measure(hi, lo);
      wr_cfg(32'h1 | EN);
      measure(hi, lo);
      chk(hi == 8 && lo == 8, "R7 ratio latched", hi, 8);
      wr_cfg(32'h1);
      idle_cyc(40);
      wr_cfg(32'h1 | EN);
      measure(hi, lo);
      chk(hi == 2 && lo == 2, "R7 ratio after restart", hi, 2);
      wr_cfg(32'h0);
      idle_cyc(20);

      // R5 bypass, with R4 priority over ratio bit 3
      wr_cfg(BYP | 32'h8 | EN);
      idle_cyc(4);
      ok = 1'b1;
      for (int i = 0; i < 6; i++) begin
         @(posedge clk); #1; if (card_clk !== 1'b1) ok = 1'b0;
         @(negedge clk); #1; if (card_clk !== 1'b0) ok = 1'b0;
      end
      chk(ok, "R5 bypass follows clock (R4 priority)", int'(ok), 1);
      wr_cfg(32'h0);
      idle_cyc(5);
      ok = 1'b1;
      for (int i = 0; i < 10; i++) begin
         @(posedge clk); #1; if (card_clk !== 1'b0) ok = 1'b0;
      end
      chk(ok, "R6 bypass stopped low", int'(ok), 1);

      // R8 idle gating
      wr_cfg(IDLE | EN);
      ones_after = 0;
      for (int i = 0; i < 30; i++) begin @(negedge clk); if (card_clk !== 1'b0) ones_after++; end
      chk(ones_after == 0, "R8 quiet while not busy", ones_after, 0);
      xfer_busy = 1'b1;
      rises = 0; prev = 1'b0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (card_clk === 1'b1 && prev === 1'b0) rises++;
         prev = card_clk;
      end
      chk(rises >= 5, "R8 runs while busy", rises, 5);
      xfer_busy = 1'b0;
      rises = 0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (card_clk === 1'b1 && prev === 1'b0) rises++;
         prev = card_clk;
      end
      chk(rises >= 3, "R8 lingers after busy", rises, 3);
      idle_cyc(6);
      ones_after = 0;
      for (int i = 0; i < 30; i++) begin @(negedge clk); if (card_clk !== 1'b0) ones_after++; end
      chk(ones_after == 0, "R8 stops after linger", ones_after, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule